// File: doc/BRIEF.md
# Serial Configuration Register Bank with Self-Clearing Calibration Start

This block accepts configuration words over a three-line serial port (clock, data, latch) and holds them in a bank of eight 24-bit registers. The serial lines are slow compared with the system clock. They are brought into the system clock domain through two-flop synchronisers, and their edges are then found in that domain. Each word is shifted in most significant bit first. A rising latch edge that follows exactly 24 clock edges commits the word to the register selected by its own low three bits. Any other bit count discards the word.

One register, the control register, holds a calibration start bit. Writing a 1 to it starts a timed calibration run. A counter of fixed length stands in for the filter search. While the run is active, the start bit reads back as 1 and the whole control register is frozen against serial writes. When the run finishes, the start bit clears itself and a 4-bit result code is stored into the result field of the same register. The run counts as valid only if the target field of the target register held the required value when the run began. A later serial write that changes the result field makes the calibration invalid again.

Top module: `ser_cfg_bank`

## Requirements
- R1: After reset every register reads zero on `cfg_flat`, and `cal_busy` and `cal_valid` are low.
- R2: A word is shifted in MSB first on rising serial clock edges. A rising latch edge after exactly 24 bits stores the word into register `w[2:0]`. That register appears at `cfg_flat[24*n +: 24]`, and no other register changes.
- R3: A rising latch edge after 23 or 25 serial bits changes no register.
- R4: A committed write to the control register (address 6) with bit 10 set, made while idle, raises `cal_busy`. Bit 10 of the control register reads 1 for as long as `cal_busy` is high.
- R5: `cal_busy` stays high for exactly `CAL_CYCLES` system clocks. When it falls, bit 10 of the control register is 0 and bits 6:3 hold bits 19:16 of the target register (address 0) as they were when the run started.
- R6: When a run ends, `cal_valid` goes high if the target field (address 0, bits 23:16) held 8'h0C at the start of the run, and stays low otherwise. `cal_valid` is low while a run is in progress.
- R7: An idle committed write to the control register whose bits 6:3 differ from the stored value clears `cal_valid`. A write that leaves bits 6:3 unchanged keeps it.
- R8: Serial writes to the control register while `cal_busy` is high have no effect.
- R9: Serial writes to registers other than the control register take effect while a calibration is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| sdat | input | 1 | Serial data, sampled on the rising `sclk` edge |
| slatch | input | 1 | Serial latch; its rising edge commits the word |
| cfg_flat | output | 192 | All eight registers; register n at bits 24*n+23 : 24*n |
| cal_busy | output | 1 | Calibration run in progress |
| cal_valid | output | 1 | Result field holds a valid calibration outcome |

## Verification
The bench sends latch pulses after 23 and after 25 bits. A design that counted bits loosely, or that kept only the last 24 bits, would commit a shifted word in one of those cases. It times the run from both sides of `CAL_CYCLES`, so an off-by-one counter, or a start bit that never clears, shows up as a busy flag that falls early or never falls. It writes the control register during a run and, once the run ends, compares the whole register against the expected value; a design that lets that write through would lose the result code or restart the run. It also rewrites the result field with the same value and with a different one, which separates a valid flag cleared on every write from one cleared only on a change.

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank #(
  parameter int WORD_W     = 24,
  parameter int NREG       = 8,
  parameter int CTRL_ADDR  = 6,
  parameter int TGT_ADDR   = 0,
  parameter int CAL_BIT    = 10,
  parameter int TC_LO      = 3,
  parameter int TC_W       = 4,
  parameter int TGT_LO     = 16,
  parameter int TGT_W      = 8,
  parameter logic [7:0] TGT_GOOD = 8'h0C,
  parameter int CAL_CYCLES = 600
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk,
  input  logic                     sdat,
  input  logic                     slatch,
  output logic [NREG*WORD_W-1:0]   cfg_flat,
  output logic                     cal_busy,
  output logic                     cal_valid
);
  localparam int AW  = $clog2(NREG);
  localparam int CW  = $clog2(CAL_CYCLES);
  localparam int BCW = $clog2(WORD_W) + 1;

  logic [2:0]        clk_s, lat_s;
  logic [1:0]        dat_s;
  logic [WORD_W-1:0] sh;
  logic [BCW-1:0]    bcnt;
  logic [WORD_W-1:0] regs [NREG];
  logic [CW-1:0]     ccnt;
  logic [TC_W-1:0]   res_q;
  logic              ok_q;

  wire sclk_rise = clk_s[1] & ~clk_s[2];
  wire lat_rise  = lat_s[1] & ~lat_s[2];
  wire commit    = lat_rise && (bcnt == BCW'(WORD_W));
  wire [AW-1:0] addr = sh[AW-1:0];
  wire wr_ctrl   = commit && (addr == AW'(CTRL_ADDR));
  wire start     = wr_ctrl && !cal_busy && sh[CAL_BIT];
  wire done      = cal_busy && (ccnt == CW'(CAL_CYCLES - 1));
  wire tc_diff   = sh[TC_LO +: TC_W] != regs[CTRL_ADDR][TC_LO +: TC_W];
  wire [TGT_W-1:0] tgt = regs[TGT_ADDR][TGT_LO +: TGT_W];
  wire [WORD_W-1:0] ctrl_q = regs[CTRL_ADDR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_s <= '0;
      lat_s <= '0;
      dat_s <= '0;
    end else begin
      clk_s <= {clk_s[1:0], sclk};
      lat_s <= {lat_s[1:0], slatch};
      dat_s <= {dat_s[0], sdat};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      bcnt <= '0;
    end else if (lat_rise) begin
      bcnt <= '0;
    end else if (sclk_rise) begin
      sh <= {sh[WORD_W-2:0], dat_s[1]};
      if (bcnt <= BCW'(WORD_W)) bcnt <= bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (commit && !(wr_ctrl && cal_busy)) regs[addr] <= sh;
      if (done) begin
        regs[CTRL_ADDR][CAL_BIT] <= 1'b0;
        regs[CTRL_ADDR][TC_LO +: TC_W] <= res_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_busy  <= 1'b0;
      cal_valid <= 1'b0;
      ccnt      <= '0;
      res_q     <= '0;
      ok_q      <= 1'b0;
    end else begin
      if (start) begin
        cal_busy  <= 1'b1;
        cal_valid <= 1'b0;
        ccnt      <= '0;
        res_q     <= tgt[TC_W-1:0];
        ok_q      <= (tgt == TGT_W'(TGT_GOOD));
      end else if (done) begin
        cal_busy  <= 1'b0;
        cal_valid <= ok_q;
      end else begin
        if (cal_busy) ccnt <= ccnt + 1'b1;
        if (wr_ctrl && !cal_busy && tc_diff) cal_valid <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_flat[g*WORD_W +: WORD_W] = regs[g];
  end
endmodule

module ser_cfg_bank_chk #(
  parameter int WORD_W     = 24,
  parameter int CAL_BIT    = 10,
  parameter int CAL_CYCLES = 600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_busy,
  input logic              cal_valid,
  input logic [WORD_W-1:0] ctrl_q
);
  localparam int KW = $clog2(CAL_CYCLES + 1) + 1;
  logic [KW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else run_len <= cal_busy ? run_len + 1'b1 : '0;
  end

  assert_start_bit_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> ctrl_q[CAL_BIT]);
  assert_run_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> run_len == KW'(CAL_CYCLES));
  assert_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> !ctrl_q[CAL_BIT]);
  assert_no_valid_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !cal_valid);
  assert_ctrl_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && $past(cal_busy)) |-> $stable(ctrl_q));
endmodule

bind ser_cfg_bank ser_cfg_bank_chk #(
  .WORD_W(WORD_W), .CAL_BIT(CAL_BIT), .CAL_CYCLES(CAL_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_busy(cal_busy),
  .cal_valid(cal_valid), .ctrl_q(ctrl_q)
);

// File: tb/ser_cfg_bank_test.sv
module ser_cfg_bank_test;
  localparam int CLK_P = 10;
  localparam int CALN  = 600;

  logic clk = 0, rst_n = 0, sclk = 0, sdat = 0, slatch = 0;
  logic [191:0] cfg_flat;
  logic cal_busy, cal_valid;
  int total = 0, bad = 0;
  logic timed_out = 0;

  ser_cfg_bank uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdat(sdat),
    .slatch(slatch), .cfg_flat(cfg_flat), .cal_busy(cal_busy), .cal_valid(cal_valid));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [23:0] rg(input int n);
    return cfg_flat[n*24 +: 24];
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdat = w[i]; ticks(4);
      sclk = 1;    ticks(4);
      sclk = 0;
    end
    ticks(4); slatch = 1; ticks(4); slatch = 0; ticks(8);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) chk("R1 reg", rg(i), 24'h0);
    chk("R1 busy", {23'b0, cal_busy}, 24'h0);
    chk("R1 valid", {23'b0, cal_valid}, 24'h0);
  endtask

  task automatic t_write;
    send(32'hA5C33B, 24);
    chk("R2 addr3", rg(3), 24'hA5C33B);
    send(32'h123457, 24);
    chk("R2 addr7", rg(7), 24'h123457);
    chk("R2 addr3 kept", rg(3), 24'hA5C33B);
    chk("R2 addr5 untouched", rg(5), 24'h0);
  endtask

  task automatic t_badcount;
    send(32'h00FF03, 23);
    chk("R3 23 bits", rg(3), 24'hA5C33B);
    send(32'h1_00FF03, 25);
    chk("R3 25 bits", rg(3), 24'hA5C33B);
    chk("R3 25 bits addr7", rg(7), 24'h123457);
  endtask

  task automatic t_cal_good;
    send(32'h0C0000, 24);
    chk("R2 target", rg(0), 24'h0C0000);
    send(32'h000406, 24);
    chk("R4 busy", {23'b0, cal_busy}, 24'h1);
    chk("R4 start bit", {23'b0, rg(6)[10]}, 24'h1);
    chk("R6 valid low in run", {23'b0, cal_valid}, 24'h0);
    send(32'h0000F6, 24);
    send(32'h0D0000, 24);
    chk("R9 target written in run", rg(0), 24'h0D0000);
    chk("R8 ctrl frozen", rg(6), 24'h000406);
    ticks(CALN - 500);
    chk("R5 still busy", {23'b0, cal_busy}, 24'h1);
    ticks(300);
    chk("R5 done", {23'b0, cal_busy}, 24'h0);
    chk("R5 ctrl after run", rg(6), 24'h000066);
    chk("R6 valid good", {23'b0, cal_valid}, 24'h1);
  endtask

  task automatic t_overwrite;
    send(32'h000066, 24);
    chk("R7 same code keeps", {23'b0, cal_valid}, 24'h1);
    send(32'h00003E, 24);
    chk("R7 new code clears", {23'b0, cal_valid}, 24'h0);
    chk("R7 stored", rg(6), 24'h00003E);
  endtask

  task automatic t_cal_bad;
    send(32'h000406, 24);
    ticks(CALN + 20);
    chk("R5 bad target code", rg(6), 24'h00006E);
    chk("R6 valid bad", {23'b0, cal_valid}, 24'h0);
  endtask

  initial begin
    ticks(3); rst_n = 1; ticks(3);
    t_reset;
    t_write;
    t_badcount;
    t_cal_good;
    t_overwrite;
    t_cal_bad;
    if (timed_out) bad++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    timed_out = 1;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule